// File: doc/BRIEF.md
# PLL dynamic retune sequencer

This block changes the output frequency of a running fractional PLL without turning it off. Software writes the integer multiplier and the fractional word into shadow registers. It then sets the update request bit in the control register. The sequencer copies the shadow values into the words it drives to the PLL and raises the latch request. It then follows the PLL's latch acknowledge through its rise and its fall. After the acknowledge has gone low again, it counts a settle interval and then reports that the new frequency is stable.

By default, hardware clears the request bit once the acknowledge is seen. A bypass control instead leaves the request high until software clears it. Each wait on the acknowledge is bounded, and a wait that runs out aborts the update with an error. A request is accepted only when the PLL is enabled and the dynamic-update capability input is high. Otherwise, the shadow values go to the PLL directly and no handshake runs.

Top module: `pll_dyn_update`

## Requirements
- R1: A control write (`wr_sel`=0) with bit 22 set is accepted only while idle with `pll_en` and `dyn_cap` both high. On the clock edge that takes the write, `pll_latch` and `busy` go high, and `pll_l`/`pll_alpha` load the shadow multiplier (`wr_sel`=1, low `L_W` bits) and fraction (`wr_sel`=2, low `A_W` bits).
- R2: `ctrl_rd` shows the request (the `pll_latch` level) at bit 22, the stored bypass bit at bit 23, `pll_ack` delayed by one register at bit 29 and `pll_lock` delayed by one register at bit 31. All other bits are 0.
- R3: For `GAP_CYC` cycles after the latch request rises, the acknowledge is not examined. An acknowledge that is high only during that window does not count.
- R4: With bypass clear, `pll_latch` falls on the edge at which the registered acknowledge is seen high.
- R5: With bypass set, `pll_latch` stays high after the acknowledge until software writes the control register with bit 22 clear. The bypass value used is the one in the accepting write.
- R6: After the latch request falls, the sequencer waits for the registered acknowledge to go low. It then counts `SETTLE_CYC` cycles, raises `done_pulse` and drops `busy`.
- R7: If the acknowledge has not risen within `TMO_CYC` cycles, or has not fallen within `TMO_CYC` cycles, `err_pulse` is raised. In the same cycle, `pll_latch` and `busy` drop.
- R8: When `pll_en` or `dyn_cap` is low, a request is ignored. While idle in that condition, `pll_l`/`pll_alpha` follow the shadow registers one cycle behind.
- R9: While busy, `pll_l` and `pll_alpha` do not change, even if the shadow registers are written.
- R10: A request written while busy is ignored.
- R11: `done_pulse` and `err_pulse` last one cycle each. `status` holds the last outcome (01 done, 10 error) and is cleared to 00 when a request is accepted.
- R12: A synchronous reset returns the block to idle, with all outputs and stored values at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 multiplier, 2 fraction |
| wr_data | input | DW | Write data |
| pll_en | input | 1 | PLL is enabled |
| dyn_cap | input | 1 | PLL supports dynamic update |
| pll_ack | input | 1 | Latch acknowledge from the PLL |
| pll_lock | input | 1 | Lock detect from the PLL |
| ctrl_rd | output | DW | Control register readback |
| pll_l | output | L_W | Multiplier driven to the PLL |
| pll_alpha | output | A_W | Fraction driven to the PLL |
| pll_latch | output | 1 | Latch request to the PLL |
| busy | output | 1 | Update in progress |
| done_pulse | output | 1 | One-cycle update complete |
| err_pulse | output | 1 | One-cycle update aborted |
| status | output | 2 | Sticky last outcome |

## Verification
The assertions check on every cycle that:
- an accepted request raises the latch in the guard phase;
- the latch drops when an acknowledge is seen with bypass clear, and holds with bypass set;
- a low acknowledge moves the sequencer into settle;
- the PLL words stay frozen while busy;
- the outcome pulses are one cycle long, and an error releases the latch and busy.

Only the bench scenarios can show the rest. These are the acknowledge that appears only inside the guard window, and the two timeout cases. They also cover refused requests when the PLL is disabled or lacks the capability, requests and shadow writes arriving mid-update, and a reset in the middle of a handshake.

// File: rtl/pll_upd_pkg.sv
package pll_upd_pkg;
  localparam int REQ_BIT  = 22;
  localparam int BYP_BIT  = 23;
  localparam int ACK_BIT  = 29;
  localparam int LOCK_BIT = 31;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_MULT = 2'd1;
  localparam logic [1:0] SEL_FRAC = 2'd2;

  localparam logic [1:0] OUT_NONE = 2'b00;
  localparam logic [1:0] OUT_DONE = 2'b01;
  localparam logic [1:0] OUT_ERR  = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GUARD, ST_RISE, ST_SWCLR, ST_FALL, ST_SETTLE
  } seq_st_e;
endpackage

// File: rtl/pll_upd_timer.sv
module pll_upd_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pll_upd_regs.sv
module pll_upd_regs
  import pll_upd_pkg::*;
#(
  parameter int DW  = 32,
  parameter int L_W = 16,
  parameter int A_W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [DW-1:0]  wr_data,
  input  logic           load_live,
  input  logic           latch,
  input  logic           ack_q,
  input  logic           lock_q,
  output logic [L_W-1:0] live_l,
  output logic [A_W-1:0] live_a,
  output logic [DW-1:0]  ctrl_rd
);
  logic [L_W-1:0] sh_l;
  logic [A_W-1:0] sh_a;
  logic           byp_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_l   <= '0;
      sh_a   <= '0;
      byp_r  <= 1'b0;
      live_l <= '0;
      live_a <= '0;
    end else begin
      if (load_live) begin
        live_l <= sh_l;
        live_a <= sh_a;
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_CTRL: byp_r <= wr_data[BYP_BIT];
          SEL_MULT: sh_l  <= wr_data[L_W-1:0];
          SEL_FRAC: sh_a  <= wr_data[A_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[REQ_BIT]  = latch;
    ctrl_rd[BYP_BIT]  = byp_r;
    ctrl_rd[ACK_BIT]  = ack_q;
    ctrl_rd[LOCK_BIT] = lock_q;
  end
endmodule

// File: rtl/pll_upd_fsm.sv
module pll_upd_fsm
  import pll_upd_pkg::*;
#(
  parameter int CW         = 11,
  parameter int GAP_CYC    = 2,
  parameter int TMO_CYC    = 64,
  parameter int SETTLE_CYC = 1250
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_req,
  input  logic          wr_byp,
  input  logic          pll_en,
  input  logic          dyn_cap,
  input  logic          ack_q,
  input  logic [CW-1:0] cnt,
  output logic          tmr_clr,
  output logic          load_live,
  output logic          latch,
  output logic          busy,
  output logic          done_p,
  output logic          err_p,
  output logic [1:0]    status
);
  seq_st_e st, nxt;
  logic    byp_run;
  logic    can_upd, start, sw_clear, to_err, to_done;
  logic    gap_end, tmo_end, set_end;

  assign can_upd   = pll_en && dyn_cap;
  assign start     = wr_ctrl && wr_req && (st == ST_IDLE) && can_upd;
  assign sw_clear  = wr_ctrl && !wr_req && (st == ST_SWCLR);
  assign load_live = start || ((st == ST_IDLE) && !can_upd);
  assign gap_end   = (cnt == CW'(GAP_CYC - 1));
  assign tmo_end   = (cnt == CW'(TMO_CYC - 1));
  assign set_end   = (cnt == CW'(SETTLE_CYC - 1));
  assign to_err    = ((st == ST_RISE) && !ack_q && tmo_end) ||
                     ((st == ST_FALL) &&  ack_q && tmo_end);
  assign to_done   = (st == ST_SETTLE) && set_end;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:   if (start) nxt = ST_GUARD;
      ST_GUARD:  if (gap_end) nxt = ST_RISE;
      ST_RISE:   if (ack_q) nxt = byp_run ? ST_SWCLR : ST_FALL;
                 else if (tmo_end) nxt = ST_IDLE;
      ST_SWCLR:  if (sw_clear) nxt = ST_FALL;
      ST_FALL:   if (!ack_q) nxt = ST_SETTLE;
                 else if (tmo_end) nxt = ST_IDLE;
      ST_SETTLE: if (set_end) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign tmr_clr = (nxt != st) || (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      byp_run <= 1'b0;
      latch   <= 1'b0;
      busy    <= 1'b0;
      done_p  <= 1'b0;
      err_p   <= 1'b0;
      status  <= OUT_NONE;
    end else begin
      st     <= nxt;
      latch  <= (nxt == ST_GUARD) || (nxt == ST_RISE) || (nxt == ST_SWCLR);
      busy   <= (nxt != ST_IDLE);
      done_p <= to_done;
      err_p  <= to_err;
      if (start) begin
        byp_run <= wr_byp;
        status  <= OUT_NONE;
      end else if (to_done) begin
        status  <= OUT_DONE;
      end else if (to_err) begin
        status  <= OUT_ERR;
      end
    end
  end

  a_r1_start_raises: assert property (@(posedge clk) disable iff (rst)
    start |=> (latch && busy && st == ST_GUARD));
  a_r3_guard_first: assert property (@(posedge clk) disable iff (rst)
    $rose(latch) |-> (st == ST_GUARD));
  a_r4_auto_clear: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RISE && ack_q && !byp_run) |=> !latch);
  a_r5_sw_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SWCLR && !sw_clear) |=> latch);
  a_r6_settle_entry: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FALL && !ack_q) |=> (st == ST_SETTLE && !latch));
endmodule

// File: rtl/pll_dyn_update.sv
module pll_dyn_update
  import pll_upd_pkg::*;
#(
  parameter int DW         = 32,
  parameter int L_W        = 16,
  parameter int A_W        = 32,
  parameter int GAP_CYC    = 2,
  parameter int TMO_CYC    = 64,
  parameter int SETTLE_CYC = 1250
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [DW-1:0]  wr_data,
  input  logic           pll_en,
  input  logic           dyn_cap,
  input  logic           pll_ack,
  input  logic           pll_lock,
  output logic [DW-1:0]  ctrl_rd,
  output logic [L_W-1:0] pll_l,
  output logic [A_W-1:0] pll_alpha,
  output logic           pll_latch,
  output logic           busy,
  output logic           done_pulse,
  output logic           err_pulse,
  output logic [1:0]     status
);
  localparam int MAX_A = (TMO_CYC > SETTLE_CYC) ? TMO_CYC : SETTLE_CYC;
  localparam int MAXC  = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  logic          ack_q, lock_q;
  logic          tmr_clr, load_live;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      ack_q  <= pll_ack;
      lock_q <= pll_lock;
    end
  end

  pll_upd_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .cnt(cnt)
  );

  pll_upd_fsm #(
    .CW(CW), .GAP_CYC(GAP_CYC), .TMO_CYC(TMO_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .wr_ctrl(wr_en && (wr_sel == SEL_CTRL)),
    .wr_req(wr_data[REQ_BIT]), .wr_byp(wr_data[BYP_BIT]),
    .pll_en(pll_en), .dyn_cap(dyn_cap), .ack_q(ack_q), .cnt(cnt),
    .tmr_clr(tmr_clr), .load_live(load_live), .latch(pll_latch),
    .busy(busy), .done_p(done_pulse), .err_p(err_pulse), .status(status)
  );

  pll_upd_regs #(.DW(DW), .L_W(L_W), .A_W(A_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .load_live(load_live), .latch(pll_latch), .ack_q(ack_q), .lock_q(lock_q),
    .live_l(pll_l), .live_a(pll_alpha), .ctrl_rd(ctrl_rd)
  );

  a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(pll_l) && $stable(pll_alpha)));
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (done_pulse || err_pulse) |=> !(done_pulse || err_pulse));
  a_r7_err_release: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (!pll_latch && !busy && status == OUT_ERR));
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done_pulse && err_pulse));
endmodule

// File: tb/pll_dyn_update_test.sv
module pll_dyn_update_test;
  localparam int GAP = 2, TMO = 16, SET = 20;
  localparam logic [31:0] REQ = 32'h0040_0000, BYP = 32'h0080_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, pll_en = 1'b0, dyn_cap = 1'b0;
  logic pll_ack = 1'b0, pll_lock = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0, ctrl_rd;
  logic [15:0] pll_l;
  logic [31:0] pll_alpha;
  logic pll_latch, busy, done_pulse, err_pulse;
  logic [1:0] status;

  always #4 clk = ~clk;

  pll_dyn_update #(.GAP_CYC(GAP), .TMO_CYC(TMO), .SETTLE_CYC(SET)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pll_en(pll_en), .dyn_cap(dyn_cap), .pll_ack(pll_ack), .pll_lock(pll_lock),
    .ctrl_rd(ctrl_rd), .pll_l(pll_l), .pll_alpha(pll_alpha),
    .pll_latch(pll_latch), .busy(busy), .done_pulse(done_pulse),
    .err_pulse(err_pulse), .status(status)
  );

  int checks = 0, failures = 0, cycles = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // PLL acknowledge responder: 0 normal, 1 never rises, 2 never falls, 3 glitch in guard
  int rmode = 0, rdly = 3, fdly = 4, hi = 0, lo = 0;
  always @(negedge clk) begin
    if (pll_latch) begin hi++; lo = 0; end else begin lo++; hi = 0; end
    case (rmode)
      0: if (pll_latch && hi > rdly) pll_ack = 1'b1;
         else if (!pll_latch && lo > fdly) pll_ack = 1'b0;
      1: pll_ack = 1'b0;
      2: if (pll_latch && hi > rdly) pll_ack = 1'b1;
      default: pll_ack = pll_latch && (hi == 1);
    endcase
  end

  // behavioural reference model
  int m_ph, m_cnt, m_latch, m_busy, m_done, m_err, m_stat, m_byp, m_bypr;
  int m_ackq, m_lockq;
  logic [15:0] m_shl, m_livel;
  logic [31:0] m_sha, m_livea;
  bit fail_now;
  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_latch = 0; m_busy = 0; m_done = 0; m_err = 0;
      m_stat = 0; m_byp = 0; m_bypr = 0; m_ackq = 0; m_lockq = 0;
      m_shl = '0; m_sha = '0; m_livel = '0; m_livea = '0;
    end else begin
      bit en, wc, rq;
      en = pll_en && dyn_cap;
      wc = wr_en && (wr_sel == 2'd0);
      rq = wr_data[22];
      m_done = 0; m_err = 0; fail_now = 0;
      case (m_ph)
        0: if (wc && rq && en) begin
             m_ph = 1; m_cnt = 0; m_latch = 1; m_busy = 1; m_stat = 0;
             m_bypr = int'(wr_data[23]); m_livel = m_shl; m_livea = m_sha;
           end else if (!en) begin
             m_livel = m_shl; m_livea = m_sha;
           end
        1: if (m_cnt == GAP-1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
        2: if (m_ackq != 0) begin
             m_ph = (m_bypr != 0) ? 3 : 4; m_cnt = 0;
             if (m_bypr == 0) m_latch = 0;
           end else if (m_cnt == TMO-1) fail_now = 1; else m_cnt++;
        3: if (wc && !rq) begin m_latch = 0; m_ph = 4; m_cnt = 0; end
        4: if (m_ackq == 0) begin m_ph = 5; m_cnt = 0; end
           else if (m_cnt == TMO-1) fail_now = 1; else m_cnt++;
        default: if (m_cnt == SET-1) begin
             m_ph = 0; m_busy = 0; m_done = 1; m_stat = 1;
           end else m_cnt++;
      endcase
      if (fail_now) begin m_ph = 0; m_latch = 0; m_busy = 0; m_err = 1; m_stat = 2; end
      if (wr_en) begin
        if (wr_sel == 2'd0) m_byp = int'(wr_data[23]);
        else if (wr_sel == 2'd1) m_shl = wr_data[15:0];
        else if (wr_sel == 2'd2) m_sha = wr_data;
      end
      m_ackq = int'(pll_ack); m_lockq = int'(pll_lock);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      logic [31:0] ectrl;
      ectrl = (32'(m_latch) << 22) | (32'(m_byp) << 23) |
              (32'(m_ackq) << 29) | (32'(m_lockq) << 31);
      chk("R4 latch", 32'(pll_latch), 32'(m_latch));
      chk("R10 busy", 32'(busy), 32'(m_busy));
      chk("R6 done", 32'(done_pulse), 32'(m_done));
      chk("R7 err", 32'(err_pulse), 32'(m_err));
      chk("R11 status", 32'(status), 32'(m_stat));
      chk("R9 pll_l", 32'(pll_l), 32'(m_livel));
      chk("R9 alpha", pll_alpha, m_livea);
      chk("R2 ctrl", ctrl_rd, ectrl);
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL R6 watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done_pulse || err_pulse) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset latch", 32'(pll_latch), 0);
    chk("R12 reset busy", 32'(busy), 0);
    chk("R12 reset status", 32'(status), 0);
    rst = 1'b0; pll_en = 1'b1; dyn_cap = 1'b1;

    wr(2'd1, 32'h0123); wr(2'd2, 32'h00AB_CDEF); wr(2'd0, REQ);
    wait_end();
    chk("R1 new L", 32'(pll_l), 32'h0123);
    chk("R1 new alpha", pll_alpha, 32'h00AB_CDEF);
    chk("R11 done status", 32'(status), 32'd1);

    wr(2'd1, 32'h0456); wr(2'd0, REQ); wr(2'd1, 32'h0999); wr(2'd0, REQ);
    wait_end();
    chk("R9 frozen L", 32'(pll_l), 32'h0456);
    chk("R10 done once", 32'(status), 32'd1);

    wr(2'd0, REQ | BYP);
    repeat (15) @(negedge clk);
    chk("R5 held latch", 32'(pll_latch), 1);
    chk("R5 still busy", 32'(busy), 1);
    wr(2'd0, BYP);
    wait_end();
    chk("R5 done after sw clear", 32'(status), 32'd1);
    wr(2'd0, 32'h0);

    rmode = 1; wr(2'd0, REQ); wait_end();
    chk("R7 rise timeout", 32'(status), 32'd2);
    rmode = 2; wr(2'd0, REQ); wait_end();
    chk("R7 fall timeout", 32'(status), 32'd2);
    rmode = 0; repeat (10) @(negedge clk);

    rmode = 3; wr(2'd0, REQ); wait_end();
    chk("R3 guard glitch ignored", 32'(status), 32'd2);
    rmode = 0;

    pll_en = 1'b0; wr(2'd1, 32'h0AAA); repeat (3) @(negedge clk);
    chk("R8 L follows shadow", 32'(pll_l), 32'h0AAA);
    wr(2'd0, REQ); repeat (3) @(negedge clk);
    chk("R8 disabled no busy", 32'(busy), 0);
    chk("R11 sticky status", 32'(status), 32'd2);
    pll_en = 1'b1; dyn_cap = 1'b0; wr(2'd0, REQ); repeat (3) @(negedge clk);
    chk("R8 no capability", 32'(busy), 0);

    dyn_cap = 1'b1; pll_lock = 1'b1; repeat (2) @(negedge clk);
    chk("R2 lock bit", 32'(ctrl_rd[31]), 1);
    wr(2'd0, REQ); wait_end();
    chk("R6 done again", 32'(status), 32'd1);

    wr(2'd0, REQ); repeat (4) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R12 mid reset latch", 32'(pll_latch), 0);
    chk("R12 mid reset busy", 32'(busy), 0);
    chk("R12 mid reset status", 32'(status), 0);
    repeat (10) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule